// File: doc/BRIEF.md
# Command Word Decoder with External Illegalization Handshake

This block receives serial-bus command words that an upstream receiver has already Manchester-decoded and checked. Each word comes with a valid strobe, an error flag that marks encoding or protocol faults, and an identifier for the bus it came from. The block acts only on clean words. For each clean word it compares the 5-bit terminal address field with the strapped address. It flags the broadcast address. It also decides whether the word is a mode command or an ordinary data-transfer command.

For an external illegalization decoder, such as a lookup ROM, the block latches four things: one 5-bit field, a mode flag that says how to read that field, the transmit/receive bit and a broadcast flag. The field carries the mode code for a mode command and the subaddress otherwise. After a programmable settling window, the block samples the active-low illegal-command reply from that decoder. It then reports the sampled verdict together with a one-cycle strobe.

Top module: `cmd_word_decoder`

## Requirements
- R1: A word is accepted only when `word_vld` is 1 and `word_err` is 0 at a clock edge. Any other word changes no latched output, produces no address-match pulse and does not restart the sampling window.
- R2: An accepted word whose bits 15:11 equal `term_addr` drives `addr_hit_n` low for exactly the one cycle after the accepting edge. Otherwise `addr_hit_n` stays high. No operating-role input gates this pulse, so it behaves the same whether the host acts as bus controller or as remote terminal.
- R3: An accepted word whose bits 9:5 are 0 or 31 is a mode command. The block sets `mode_cmd` to 1 and drives bits 4:0 onto `sel_fld`.
- R4: An accepted word whose bits 9:5 are in the range 1 to 30 sets `mode_cmd` to 0 and drives bits 9:5 onto `sel_fld`.
- R5: `tr_bit` takes bit 10 of the accepted word and `cmd_bus` takes `word_bus`. Together with `sel_fld` and `mode_cmd`, these hold their values until the next accepted word.
- R6: `bcast_rcv` is 1 when the accepted word's bits 15:11 are 31, and 0 otherwise. It holds until the next accepted word.
- R7: Let the accepting edge be edge k. At edge k+SAMPLE_CYCLES the block samples `illegal_n`. It then raises `ill_done` for one cycle and sets `cmd_illegal` to the inverse of the sampled value. The default SAMPLE_CYCLES of 63 is at least 250 ns at 250 MHz.
- R8: Each accepted word clears `cmd_illegal` and restarts the sampling window. A window cut short by a new word never produces `ill_done`.
- R9: After reset `sel_fld`, `mode_cmd`, `tr_bit`, `bcast_rcv`, `cmd_bus`, `ill_done` and `cmd_illegal` are 0, and `addr_hit_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_vld | input | 1 | Command word strobe |
| word_err | input | 1 | Word has an encoding or protocol fault |
| word_bus | input | 1 | Bus the word arrived on |
| word_data | input | 16 | Command word |
| term_addr | input | 5 | Strapped terminal address |
| illegal_n | input | 1 | Active-low illegal reply from external decoder |
| addr_hit_n | output | 1 | Active-low one-cycle address-match pulse |
| sel_fld | output | 5 | Mode code or subaddress, per `mode_cmd` |
| mode_cmd | output | 1 | Latched mode-command flag |
| tr_bit | output | 1 | Latched transmit/receive bit |
| bcast_rcv | output | 1 | Latched broadcast-received flag |
| cmd_bus | output | 1 | Latched bus identifier |
| ill_done | output | 1 | One-cycle strobe when the illegal reply is sampled |
| cmd_illegal | output | 1 | Sampled illegal verdict for the current command |

## Verification
Some properties can be checked on every cycle, and the assertions do that. Latched outputs stay still when no word is accepted. An address-match pulse only ever follows an accepted word whose address matches. The mode flag matches the subaddress class of the word before it. `ill_done` fires exactly SAMPLE_CYCLES edges after the latest acceptance, carrying the inverse of the `illegal_n` value seen at that edge. Other behaviours need the bench's scenarios, because they depend on the exact field values and on timing:
- the selected field contents across a sweep of every address, subaddress and direction against several strapped addresses;
- the broadcast flag;
- rejection of faulted words;
- an `illegal_n` pulse placed on the sampling edge versus one placed a cycle early;
- a window restarted before it ends.

// File: rtl/cwd_pkg.sv
package cwd_pkg;

    parameter int WORD_W = 16;
    parameter int FLD_W  = 5;
    parameter int ADDR_W = 5;

    localparam int WC_LSB   = 0;
    localparam int SA_LSB   = FLD_W;
    localparam int TR_POS   = 2 * FLD_W;
    localparam int ADDR_LSB = TR_POS + 1;

    typedef struct packed {
        logic [FLD_W-1:0] fld;
        logic             mode;
        logic             tr;
        logic             bcast;
        logic             bus;
        logic             hit_n;
    } cwd_latch_t;

endpackage

// File: rtl/cwd_field_split.sv
module cwd_field_split
    import cwd_pkg::*;
#(
    parameter bit MODE_ALL_ONES = 1'b1
) (
    input  logic [WORD_W-1:0] word,
    input  logic [ADDR_W-1:0] my_addr,
    output logic              addr_eq,
    output logic              is_bcast,
    output logic              is_mode,
    output logic              tr,
    output logic [FLD_W-1:0]  fld
);
    logic [ADDR_W-1:0] addr_f;
    logic [FLD_W-1:0]  sa_f;
    logic [FLD_W-1:0]  wc_f;
    logic              sa_zero;

    assign addr_f  = word[ADDR_LSB +: ADDR_W];
    assign sa_f    = word[SA_LSB +: FLD_W];
    assign wc_f    = word[WC_LSB +: FLD_W];
    assign tr      = word[TR_POS];
    assign addr_eq = (addr_f == my_addr);
    assign is_bcast = &addr_f;
    assign sa_zero = ~|sa_f;

    generate
        if (MODE_ALL_ONES) begin : g_two_codes
            assign is_mode = sa_zero | (&sa_f);
        end else begin : g_zero_only
            assign is_mode = sa_zero;
        end
    endgenerate

    assign fld = is_mode ? wc_f : sa_f;
endmodule

// File: rtl/cwd_illegal_sampler.sv
module cwd_illegal_sampler #(
    parameter int SAMPLE_CYCLES = 63
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic illegal_n,
    output logic done,
    output logic illegal
);
    localparam int CNT_W = $clog2(SAMPLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(SAMPLE_CYCLES - 1);

    typedef struct packed {
        logic             wait_on;
        logic [CNT_W-1:0] cnt;
        logic             done;
        logic             illegal;
    } smp_t;

    smp_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (start) begin
            s_d.wait_on = 1'b1;
            s_d.cnt     = CNT_INIT;
            s_d.illegal = 1'b0;
        end else if (s_q.wait_on) begin
            if (s_q.cnt == '0) begin
                s_d.wait_on = 1'b0;
                s_d.done    = 1'b1;
                s_d.illegal = ~illegal_n;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign done    = s_q.done;
    assign illegal = s_q.illegal;
endmodule

// File: rtl/cmd_word_decoder.sv
module cmd_word_decoder
    import cwd_pkg::*;
#(
    parameter int SAMPLE_CYCLES = 63,
    parameter bit MODE_ALL_ONES = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_vld,
    input  logic              word_err,
    input  logic              word_bus,
    input  logic [WORD_W-1:0] word_data,
    input  logic [ADDR_W-1:0] term_addr,
    input  logic              illegal_n,
    output logic              addr_hit_n,
    output logic [FLD_W-1:0]  sel_fld,
    output logic              mode_cmd,
    output logic              tr_bit,
    output logic              bcast_rcv,
    output logic              cmd_bus,
    output logic              ill_done,
    output logic              cmd_illegal
);
    localparam cwd_latch_t LATCH_RST = '{fld: '0, mode: 1'b0, tr: 1'b0,
                                         bcast: 1'b0, bus: 1'b0, hit_n: 1'b1};

    logic             acc;
    logic             w_addr_eq;
    logic             w_bcast;
    logic             w_mode;
    logic             w_tr;
    logic [FLD_W-1:0] w_fld;

    cwd_latch_t lt_d, lt_q;

    assign acc = word_vld & ~word_err;

    cwd_field_split #(
        .MODE_ALL_ONES(MODE_ALL_ONES)
    ) split_i (
        .word     (word_data),
        .my_addr  (term_addr),
        .addr_eq  (w_addr_eq),
        .is_bcast (w_bcast),
        .is_mode  (w_mode),
        .tr       (w_tr),
        .fld      (w_fld)
    );

    always_comb begin
        lt_d       = lt_q;
        lt_d.hit_n = 1'b1;
        if (acc) begin
            lt_d.fld   = w_fld;
            lt_d.mode  = w_mode;
            lt_d.tr    = w_tr;
            lt_d.bcast = w_bcast;
            lt_d.bus   = word_bus;
            lt_d.hit_n = ~w_addr_eq;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lt_q <= LATCH_RST;
        else        lt_q <= lt_d;
    end

    cwd_illegal_sampler #(
        .SAMPLE_CYCLES(SAMPLE_CYCLES)
    ) smp_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (acc),
        .illegal_n (illegal_n),
        .done      (ill_done),
        .illegal   (cmd_illegal)
    );

    assign addr_hit_n = lt_q.hit_n;
    assign sel_fld    = lt_q.fld;
    assign mode_cmd   = lt_q.mode;
    assign tr_bit     = lt_q.tr;
    assign bcast_rcv  = lt_q.bcast;
    assign cmd_bus    = lt_q.bus;
endmodule

// File: rtl/cwd_checker.sv
module cwd_checker
    import cwd_pkg::*;
#(
    parameter int SAMPLE_CYCLES = 63
) (
    input logic              clk,
    input logic              rst_n,
    input logic              word_vld,
    input logic              word_err,
    input logic [WORD_W-1:0] word_data,
    input logic [ADDR_W-1:0] term_addr,
    input logic              illegal_n,
    input logic              addr_hit_n,
    input logic [FLD_W-1:0]  sel_fld,
    input logic              mode_cmd,
    input logic              tr_bit,
    input logic              bcast_rcv,
    input logic              cmd_bus,
    input logic              ill_done,
    input logic              cmd_illegal
);
    localparam int GW = $clog2(SAMPLE_CYCLES + 2);
    localparam logic [GW-1:0] GMAX = GW'(SAMPLE_CYCLES + 1);

    logic          acc_c;
    logic [GW-1:0] gap_q;

    assign acc_c = word_vld & ~word_err;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            gap_q <= GMAX;
        else if (acc_c)        gap_q <= '0;
        else if (gap_q != GMAX) gap_q <= gap_q + 1'b1;
    end

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_c |=> $stable({sel_fld, mode_cmd, tr_bit, bcast_rcv, cmd_bus})); // R1

    AST_HIT_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_c |=> addr_hit_n); // R2

    AST_HIT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        acc_c |=> (addr_hit_n == ($past(word_data[15:11]) != $past(term_addr)))); // R2

    AST_MODE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_c |=> (mode_cmd == (($past(word_data[9:5]) == 5'd0) ||
                                ($past(word_data[9:5]) == 5'd31)))); // R3

    AST_DONE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        ill_done |-> (gap_q == GW'(SAMPLE_CYCLES))); // R7

    AST_DONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ill_done) |-> (cmd_illegal == !$past(illegal_n))); // R7

    AST_ACC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_c |=> (!cmd_illegal && !ill_done)); // R8
endmodule

bind cmd_word_decoder cwd_checker #(.SAMPLE_CYCLES(SAMPLE_CYCLES)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_vld   (word_vld),
    .word_err   (word_err),
    .word_data  (word_data),
    .term_addr  (term_addr),
    .illegal_n  (illegal_n),
    .addr_hit_n (addr_hit_n),
    .sel_fld    (sel_fld),
    .mode_cmd   (mode_cmd),
    .tr_bit     (tr_bit),
    .bcast_rcv  (bcast_rcv),
    .cmd_bus    (cmd_bus),
    .ill_done   (ill_done),
    .cmd_illegal(cmd_illegal)
);

// File: tb/cmd_word_decoder_tb_top.sv
`timescale 1ns/1ps
module cmd_word_decoder_tb_top;
    localparam int S = 63;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_vld = 1'b0;
    logic        word_err = 1'b0;
    logic        word_bus = 1'b0;
    logic [15:0] word_data = '0;
    logic [4:0]  term_addr = '0;
    logic        illegal_n = 1'b1;
    logic        addr_hit_n;
    logic [4:0]  sel_fld;
    logic        mode_cmd, tr_bit, bcast_rcv, cmd_bus, ill_done, cmd_illegal;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    cmd_word_decoder #(.SAMPLE_CYCLES(S)) dut_i (
        .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word_err(word_err),
        .word_bus(word_bus), .word_data(word_data), .term_addr(term_addr),
        .illegal_n(illegal_n), .addr_hit_n(addr_hit_n), .sel_fld(sel_fld),
        .mode_cmd(mode_cmd), .tr_bit(tr_bit), .bcast_rcv(bcast_rcv),
        .cmd_bus(cmd_bus), .ill_done(ill_done), .cmd_illegal(cmd_illegal)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Called at a negedge; returns at the next negedge, after the capturing edge.
    task automatic send(input logic [15:0] w, input logic e, input logic b);
        word_data = w; word_err = e; word_bus = b; word_vld = 1'b1;
        @(negedge clk);
        word_vld = 1'b0; word_err = 1'b0;
    endtask

    function automatic logic [15:0] mk(input int a, input int t, input int sa, input int wc);
        return {a[4:0], t[0], sa[4:0], wc[4:0]};
    endfunction

    task automatic check_latch(input string tag, input int fld, input int md,
                               input int tr, input int bc, input int bus);
        check({tag, " R3/R4 sel_fld"}, sel_fld, fld);
        check({tag, " R3/R4 mode_cmd"}, mode_cmd, md);
        check({tag, " R5 tr_bit"}, tr_bit, tr);
        check({tag, " R6 bcast_rcv"}, bcast_rcv, bc);
        check({tag, " R5 cmd_bus"}, cmd_bus, bus);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        int e_fld, e_md, e_bc, e_bus, my;
        int mys[3] = '{0, 13, 31};
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 addr_hit_n", addr_hit_n, 1);
        check_latch("R9", 0, 0, 0, 0, 0);
        check("R9 ill_done", ill_done, 0);
        check("R9 cmd_illegal", cmd_illegal, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Sweep every address, subaddress and direction against several strapped addresses
        for (int m = 0; m < 3; m++) begin
            my = mys[m];
            term_addr = my[4:0];
            for (int a = 0; a < 32; a++) begin
                for (int sa = 0; sa < 32; sa++) begin
                    for (int t = 0; t < 2; t++) begin
                        int wc;
                        wc = (a * 7 + sa * 3 + t) % 32;
                        e_md  = (sa == 0 || sa == 31) ? 1 : 0;
                        e_fld = e_md ? wc : sa;
                        e_bc  = (a == 31) ? 1 : 0;
                        e_bus = (a + sa + t) % 2;
                        send(mk(a, t, sa, wc), 1'b0, e_bus[0]);
                        check("R2 addr_hit_n pulse", addr_hit_n, (a == my) ? 0 : 1);
                        check_latch("sweep", e_fld, e_md, t, e_bc, e_bus);
                        if (((a + sa + t) % 4) == 0) begin
                            // R1 faulted word with other contents: nothing moves
                            send(mk(my, 1 - t, (sa + 5) % 32, (wc + 9) % 32), 1'b1, ~e_bus[0]);
                            check("R1 faulted word no pulse", addr_hit_n, 1);
                            check_latch("R1 faulted", e_fld, e_md, t, e_bc, e_bus);
                        end else begin
                            @(negedge clk);
                            check("R2 pulse one cycle", addr_hit_n, 1);
                        end
                        check("R8 no done on short window", ill_done, 0);
                    end
                end
            end
        end

        // R7 illegal_n low only on the sampling edge
        term_addr = 5'd3;
        send(mk(3, 1, 0, 17), 1'b0, 1'b1);
        repeat (S - 1) begin
            check("R7 no early done", ill_done, 0);
            @(negedge clk);
        end
        illegal_n = 1'b0;
        @(negedge clk);
        illegal_n = 1'b1;
        check("R7 ill_done on sample edge", ill_done, 1);
        check("R7 cmd_illegal sampled low", cmd_illegal, 1);
        @(negedge clk);
        check("R7 ill_done one cycle", ill_done, 0);
        check("R7 cmd_illegal held", cmd_illegal, 1);

        // R8 new word clears verdict; R1 vld without clean word does not restart
        send(mk(4, 0, 6, 2), 1'b0, 1'b0);
        check("R8 cmd_illegal cleared", cmd_illegal, 0);
        check_latch("R4 after clear", 6, 0, 0, 0, 0);

        // R7 illegal_n low one cycle early only: not seen
        repeat (S - 2) @(negedge clk);
        illegal_n = 1'b0;
        @(negedge clk);
        illegal_n = 1'b1;
        check("R7 no done before edge", ill_done, 0);
        @(negedge clk);
        check("R7 done at edge", ill_done, 1);
        check("R7 early low missed", cmd_illegal, 0);

        // R8 restart window mid-way
        send(mk(9, 1, 31, 4), 1'b0, 1'b0);
        repeat (20) @(negedge clk);
        send(mk(9, 0, 12, 4), 1'b0, 1'b1);
        illegal_n = 1'b0;
        repeat (S - 1) begin
            check("R8 restarted window no done", ill_done, 0);
            @(negedge clk);
        end
        @(negedge clk);
        check("R8 done after restart", ill_done, 1);
        check("R8 verdict after restart", cmd_illegal, 1);
        illegal_n = 1'b1;

        // R1 faulted word during a window does not restart it
        send(mk(9, 0, 12, 4), 1'b0, 1'b0);
        repeat (10) @(negedge clk);
        send(mk(2, 1, 1, 1), 1'b1, 1'b1);
        repeat (S - 12) @(negedge clk);
        check("R1 window unaffected pre", ill_done, 0);
        @(negedge clk);
        check("R1 window unaffected done", ill_done, 1);
        check_latch("R1 latch unaffected", 12, 0, 0, 0, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule